// File: doc/BRIEF.md
# Flash Status Polling Bit Generator

This block forms the status bits that a flash device returns on reads while its internal program or erase controller is busy. The surrounding controller supplies the current operation mode, whether the read address lies inside a block being erased (or, after a failure, inside the faulty block), bit 7 of the byte being programmed, pass/fail events, read/reset commands and block-erase command events. On every read strobe the block captures five status bits. Software can poll these bits to tell what the device is doing and whether the last operation failed.

Two toggle flip-flops give the alternating bits. The busy toggle flips once per qualifying read in the program, erase and suspend-program modes. The block toggle flips once per read that targets a block under erase, or a faulty block after a failure. An error flag stays set until a read/reset command or a successful completion clears it. The erase-window bit is driven by a down-counter that a block-erase command reloads. It reads low until the window has run out.

Top module: `flash_status_poll`

## Requirements
- R1: After reset, `poll_bit`, `tog_bit`, `tmr_bit` and `blk_bit` are 1 and `err_bit` is 0.
- R2: The outputs are registered. They change only at the clock edge that samples `rd` high, and they hold their value through every cycle in which `rd` is low.
- R3: In program mode (`mode`=1), a read gives `poll_bit` equal to the inverse of `prog_d7`, `blk_bit`=1, and `tog_bit` equal to the busy toggle after its flip.
- R4: In erase mode (`mode`=2), a read gives `poll_bit`=0, and `tog_bit` equal to the busy toggle after its flip.
- R5: In erase mode, `blk_bit` follows the block toggle after its flip when `addr_in_erase` or `chip_erase` is high. Otherwise `blk_bit` reads 1 and the block toggle keeps its value.
- R6: In erase-suspend mode (`mode`=3), a read gives `poll_bit`=1 and `tog_bit`=1. `blk_bit` follows the block toggle after its flip when the address is in the suspended block (`addr_in_erase` or `chip_erase`). Otherwise `blk_bit` reads 1.
- R7: In suspend-program mode (`mode`=4), a read gives `poll_bit` equal to the inverse of `prog_d7`, `tog_bit` equal to the busy toggle after its flip, and `blk_bit`=1.
- R8: A `fail` pulse sets the error flag. `rd_reset` or `op_ok` clears it, and `fail` wins when both arrive in the same cycle. A read reports the flag on `err_bit`.
- R9: In idle mode (`mode`=0, or any unused code), `poll_bit`=1 and `tog_bit`=1. `blk_bit` follows the block toggle when the error flag is set and `addr_in_fault` is high. Otherwise it reads 1.
- R10: Take the clock edge that samples `blk_erase_cmd`. A read sampled 1 to WIN_CYCLES edges later reports `tmr_bit`=0. A later read reports 1. A new command inside the window restarts the count.
- R11: Each toggle flip-flop starts at 0 and flips at most once per read strobe, whatever the length of the strobe gap. The busy toggle flips only in modes 1, 2 and 4. The block toggle flips only under the conditions of R5, R6 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | 0 idle, 1 program, 2 erase, 3 erase suspend, 4 suspend-program |
| chip_erase | input | 1 | The erase covers every block |
| addr_in_erase | input | 1 | The read address is in a block under erase or suspend |
| addr_in_fault | input | 1 | The read address is in the block whose operation failed |
| prog_d7 | input | 1 | Bit 7 of the byte being programmed |
| fail | input | 1 | Pulse: the operation failed |
| op_ok | input | 1 | Pulse: the operation completed successfully |
| rd_reset | input | 1 | Pulse: read/reset command accepted |
| blk_erase_cmd | input | 1 | Pulse: block-erase command accepted |
| rd | input | 1 | Read strobe, one cycle per read |
| poll_bit | output | 1 | Data-polling status bit |
| tog_bit | output | 1 | Busy toggle status bit |
| err_bit | output | 1 | Error status bit |
| tmr_bit | output | 1 | Erase-window status bit |
| blk_bit | output | 1 | Block toggle status bit |

## Verification
Some properties are checked on every cycle:
- the outputs hold between strobes;
- erase forces the polling bit low;
- program reports the inverted data bit with the block bit high;
- suspend forces both high;
- each toggle flip-flop stays still without a strobe;
- a failure sets the error flag, and a clear without a failure clears it;
- a read right after a block-erase command sees the window bit low.

Only the bench scenarios show the following:
- the alternating sequences across many reads and across mode changes;
- the inside/outside-block distinction together with the chip-erase override;
- the fault-block toggle after an error;
- the exact edge at which the erase window ends, and its restart.

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
  parameter int WIN_CYCLES = 40,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       chip_erase,
  input  logic       addr_in_erase,
  input  logic       addr_in_fault,
  input  logic       prog_d7,
  input  logic       fail,
  input  logic       op_ok,
  input  logic       rd_reset,
  input  logic       blk_erase_cmd,
  input  logic       rd,
  output logic       poll_bit,
  output logic       tog_bit,
  output logic       err_bit,
  output logic       tmr_bit,
  output logic       blk_bit
);

  localparam logic [2:0] M_PROG  = 3'd1;
  localparam logic [2:0] M_ERASE = 3'd2;
  localparam logic [2:0] M_SUSP  = 3'd3;
  localparam logic [2:0] M_SPROG = 3'd4;

  logic          busy_t, blk_t, err;
  logic [CW-1:0] win_cnt;

  wire is_prog  = (mode == M_PROG);
  wire is_erase = (mode == M_ERASE);
  wire is_susp  = (mode == M_SUSP);
  wire is_sprog = (mode == M_SPROG);
  wire is_idle  = !(is_prog || is_erase || is_susp || is_sprog);
  wire in_blk   = chip_erase || addr_in_erase;

  wire busy_flip = rd && (is_prog || is_erase || is_sprog);
  wire blk_flip  = rd && ((is_erase && in_blk) || (is_susp && in_blk) ||
                          (is_idle && err && addr_in_fault));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_t <= 1'b0;
      blk_t  <= 1'b0;
    end else begin
      if (busy_flip) busy_t <= ~busy_t;
      if (blk_flip)  blk_t  <= ~blk_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err <= 1'b0;
    else if (fail)              err <= 1'b1;
    else if (rd_reset || op_ok) err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             win_cnt <= '0;
    else if (blk_erase_cmd) win_cnt <= CW'(WIN_CYCLES);
    else if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_bit <= 1'b1;
      tog_bit  <= 1'b1;
      err_bit  <= 1'b0;
      tmr_bit  <= 1'b1;
      blk_bit  <= 1'b1;
    end else if (rd) begin
      poll_bit <= (is_prog || is_sprog) ? ~prog_d7 : !is_erase;
      tog_bit  <= busy_flip ? ~busy_t : 1'b1;
      blk_bit  <= blk_flip ? ~blk_t : 1'b1;
      err_bit  <= err;
      tmr_bit  <= (win_cnt == '0);
    end
  end

  a_r2_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable({poll_bit, tog_bit, err_bit, tmr_bit, blk_bit}));

  a_r3_prog_polls_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    rd && mode == M_PROG |=> blk_bit && (poll_bit == !$past(prog_d7)));

  a_r4_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd && mode == M_ERASE |=> !poll_bit);

  a_r6_suspend_high: assert property (@(posedge clk) disable iff (!rst_n)
    rd && mode == M_SUSP |=> poll_bit && tog_bit);

  a_r8_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> err);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reset || op_ok) && !fail |=> !err);

  a_r10_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    blk_erase_cmd ##1 rd |=> !tmr_bit);

  a_r11_toggles_still: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(busy_t) && $stable(blk_t));

endmodule

// File: tb/tb_flash_status_poll.sv
module tb_flash_status_poll;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic chip_erase = 0, addr_in_erase = 0, addr_in_fault = 0, prog_d7 = 0;
  logic fail = 0, op_ok = 0, rd_reset = 0, blk_erase_cmd = 0, rd = 0;
  logic poll_bit, tog_bit, err_bit, tmr_bit, blk_bit;

  int total = 0, bad = 0;
  logic rd_d = 0;
  logic [4:0] q_exp[$];
  string q_tag[$];
  logic m_busy = 0, m_blk = 0, m_err = 0, m_tmr = 1;
  logic done = 0;

  flash_status_poll #(.WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .chip_erase(chip_erase),
    .addr_in_erase(addr_in_erase), .addr_in_fault(addr_in_fault),
    .prog_d7(prog_d7), .fail(fail), .op_ok(op_ok), .rd_reset(rd_reset),
    .blk_erase_cmd(blk_erase_cmd), .rd(rd), .poll_bit(poll_bit),
    .tog_bit(tog_bit), .err_bit(err_bit), .tmr_bit(tmr_bit), .blk_bit(blk_bit));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) rd_d <= rd;

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got p/t/e/m/b=%b expected %b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_d && q_exp.size() > 0) begin
      check({poll_bit, tog_bit, err_bit, tmr_bit, blk_bit}, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] m, input logic ae, input logic ce,
                         input logic af, input logic d7, input string tag);
    logic p, t, b;
    mode = m; addr_in_erase = ae; chip_erase = ce; addr_in_fault = af; prog_d7 = d7;
    p = 1'b1; t = 1'b1; b = 1'b1;
    case (m)
      3'd1: begin p = ~d7; m_busy = ~m_busy; t = m_busy; end
      3'd2: begin p = 1'b0; m_busy = ~m_busy; t = m_busy;
                  if (ae || ce) begin m_blk = ~m_blk; b = m_blk; end end
      3'd3: if (ae || ce) begin m_blk = ~m_blk; b = m_blk; end
      3'd4: begin p = ~d7; m_busy = ~m_busy; t = m_busy; end
      default: if (m_err && af) begin m_blk = ~m_blk; b = m_blk; end
    endcase
    q_exp.push_back({p, t, m_err, m_tmr, b});
    q_tag.push_back(tag);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_fail(input logic f, input logic ok, input logic rr);
    fail = f; op_ok = ok; rd_reset = rr;
    if (f) m_err = 1'b1; else if (ok || rr) m_err = 1'b0;
    @(negedge clk);
    fail = 0; op_ok = 0; rd_reset = 0;
  endtask

  task automatic erase_cmd();
    blk_erase_cmd = 1'b1;
    @(negedge clk);
    blk_erase_cmd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check({poll_bit, tog_bit, err_bit, tmr_bit, blk_bit}, 5'b11011, "R1 reset state");

    do_read(3'd1, 0, 0, 0, 1'b1, "R3 program d7=1 read1");
    do_read(3'd1, 0, 0, 0, 1'b1, "R3 program d7=1 read2");
    do_read(3'd1, 0, 0, 0, 1'b0, "R3 program d7=0 read3");
    held = {poll_bit, tog_bit, err_bit, tmr_bit, blk_bit};
    cyc(5);
    check({poll_bit, tog_bit, err_bit, tmr_bit, blk_bit}, held, "R2 hold without strobe");
    check({poll_bit, tog_bit, err_bit, tmr_bit, blk_bit}, 5'b11011, "R2 R11 held value of read3");

    do_read(3'd2, 1, 0, 0, 0, "R4 R5 erase in block a");
    do_read(3'd2, 1, 0, 0, 0, "R4 R5 erase in block b");
    do_read(3'd2, 0, 0, 0, 0, "R5 erase outside block");
    cyc(3);
    do_read(3'd2, 0, 1, 0, 0, "R5 chip erase toggles");
    do_read(3'd2, 1, 0, 0, 0, "R11 block toggle resumes");

    do_read(3'd3, 1, 0, 0, 0, "R6 suspend inside a");
    do_read(3'd3, 1, 0, 0, 0, "R6 suspend inside b");
    do_read(3'd3, 0, 0, 0, 0, "R6 suspend outside");
    do_read(3'd4, 0, 0, 0, 1'b0, "R7 suspend-program a");
    do_read(3'd4, 0, 0, 0, 1'b1, "R7 suspend-program b");

    do_read(3'd0, 0, 0, 1, 0, "R9 idle no error fault addr");
    pulse_fail(1, 0, 0);
    do_read(3'd0, 0, 0, 0, 0, "R8 error set");
    do_read(3'd0, 0, 0, 1, 0, "R9 faulty block toggles a");
    do_read(3'd0, 0, 0, 1, 0, "R9 faulty block toggles b");
    do_read(3'd0, 0, 0, 0, 0, "R9 other block reads 1");
    pulse_fail(0, 1, 0);
    do_read(3'd0, 0, 0, 1, 0, "R8 cleared by success");
    pulse_fail(1, 0, 0);
    pulse_fail(0, 0, 1);
    do_read(3'd0, 0, 0, 0, 0, "R8 cleared by read/reset");
    pulse_fail(1, 0, 1);
    do_read(3'd0, 0, 0, 0, 0, "R8 fail wins over clear");
    pulse_fail(0, 0, 1);

    erase_cmd();
    m_tmr = 1'b0;
    do_read(3'd0, 0, 0, 0, 0, "R10 window first edge");
    cyc(WIN - 2);
    do_read(3'd0, 0, 0, 0, 0, "R10 window last edge");
    m_tmr = 1'b1;
    do_read(3'd0, 0, 0, 0, 0, "R10 window expired");

    erase_cmd();
    cyc(WIN - 2);
    erase_cmd();
    cyc(WIN - 1);
    m_tmr = 1'b0;
    do_read(3'd2, 1, 0, 0, 0, "R10 restart keeps window open");
    m_tmr = 1'b1;
    do_read(3'd2, 1, 0, 0, 0, "R10 restarted window expired");

    cyc(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule